// File: doc/BRIEF.md
# Byte-Stepped I2C Master Engine

This block is an I2C bus master that moves forward one bus event at a time under software control. Software writes a control word and a data byte. The engine then performs exactly one step on the bus: a START, a repeated START, one byte with its acknowledge bit, or a STOP. When a START or a byte step finishes, the engine raises an event flag and publishes an eight-bit status code. It stays parked, with the bus held as it was left, until software issues the next control write.

The SCL and SDA lines are driven open-drain: each output means "pull the line low". Each bit takes four phases, and the engine moves to the next phase on each pulse of `scl_tick`, so the bus rate is set outside the block. On bits the master drives high, the engine watches SDA. If SDA reads low, another master has won the bus. The engine then lets go of both lines and reports the loss. For each received byte, the acknowledge-enable bit latched by the control write that started the step decides whether the master sends ACK or NAK.

Top module: `i2c_byte_master`

## Requirements
- R1: After synchronous reset, status is 0xF8, the flag and the interrupt are low, and neither SCL nor SDA is pulled low.
- R2: Control word bits are: enable = bit 5, start = bit 4, stop = bit 3, flag = bit 2, acknowledge-enable = bit 1, interrupt-enable = bit 0. From idle, a write with enable and start set produces a START condition (SDA falls while SCL is high), then sets the flag with status 0x08.
- R3: While the flag is set and no control write occurs, the flag stays set, the status holds, and the SCL/SDA drive does not change.
- R4: An enabled write with flag = 0 after a START sends the data register MSB first as the address byte. The status is then 0x18/0x20 (ACK/NAK) when bit 0 is 0 (write), and 0x40/0x48 when bit 0 is 1 (read).
- R5: In a write transfer, each released step sends the data register. The status is then 0x28 if the target ACKs and 0x30 if it NAKs.
- R6: In a read transfer, each released step receives one byte, MSB first. That byte is in the data register when the flag rises. The master ACKs with status 0x50 when acknowledge-enable was set, and NAKs with status 0x58 when it was clear.
- R7: A start write while the flag is set after an earlier step produces a repeated START with status 0x10.
- R8: A write with enable and stop produces a STOP condition (SDA rises while SCL is high). Both lines are then released, the status returns to 0xF8 and the flag stays clear.
- R9: If SDA reads low during a bit the master drives high, the engine releases both lines, sets status 0x38 and sets the flag. A following START reports 0x08, not 0x10.
- R10: The interrupt output equals the flag ANDed with the interrupt-enable bit from the last control write.
- R11: A control write with the enable bit clear starts no bus event and does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_tick | input | 1 | Phase advance strobe, one quarter bit period |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word (bit map in R2) |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | BYTE_W | Byte to send |
| sda_in | input | 1 | Sampled SDA line level |
| dat_rdata | output | BYTE_W | Data register contents |
| stat | output | 8 | Status code of the last event |
| flag | output | 1 | Event flag |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
The hardest state to reach is arbitration loss. It needs another agent to hold SDA low at the exact moment the master releases it for a one bit and samples it. The bench reaches it with a separate pull-down on the bench's SDA wire. That pull-down is asserted just after a START, before an address whose top bit is one. This yields the lost code with both lines released. A fresh START then confirms that bus ownership was dropped. Read bursts that end in a NAK, data bytes the target model refuses (0xFF), and absent addresses are mixed in at random between directed sequences.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {OP_START, OP_BIT, OP_STOP} phy_op_t;
  typedef enum logic [2:0] {SQ_IDLE, SQ_START, SQ_BYTE, SQ_STOP, SQ_HOLD} seq_st_t;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_WA_ACK  = 8'h18;
  localparam logic [7:0] ST_WA_NAK  = 8'h20;
  localparam logic [7:0] ST_TD_ACK  = 8'h28;
  localparam logic [7:0] ST_TD_NAK  = 8'h30;
  localparam logic [7:0] ST_ARB     = 8'h38;
  localparam logic [7:0] ST_RA_ACK  = 8'h40;
  localparam logic [7:0] ST_RA_NAK  = 8'h48;
  localparam logic [7:0] ST_RD_ACK  = 8'h50;
  localparam logic [7:0] ST_RD_NAK  = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  localparam int CTL_W  = 6;
  localparam int CB_IEN = 0;
  localparam int CB_AAK = 1;
  localparam int CB_FLG = 2;
  localparam int CB_STP = 3;
  localparam int CB_STA = 4;
  localparam int CB_EN  = 5;
endpackage

// File: rtl/i2cm_bitphy.sv
module i2cm_bitphy
  import i2cm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tick,
  input  logic    cmd_valid,
  input  phy_op_t cmd_op,
  input  logic    cmd_txb,
  input  logic    cmd_chk,
  input  logic    sda_in,
  output logic    busy,
  output logic    done,
  output logic    lost,
  output logic    rxb,
  output logic    scl_lo,
  output logic    sda_lo
);
  logic [1:0] ph;
  phy_op_t    op;
  logic       txb, chk;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; lost <= 1'b0; rxb <= 1'b1;
      scl_lo <= 1'b0; sda_lo <= 1'b0; ph <= 2'd0;
      op <= OP_START; txb <= 1'b0; chk <= 1'b0;
    end else begin
      done <= 1'b0;
      lost <= 1'b0;
      if (!busy && cmd_valid) begin
        busy <= 1'b1; ph <= 2'd0; op <= cmd_op; txb <= cmd_txb; chk <= cmd_chk;
      end else if (busy && tick) begin
        ph <= ph + 2'd1;
        case (op)
          OP_START: case (ph)
            2'd0: sda_lo <= 1'b0;
            2'd1: scl_lo <= 1'b0;
            2'd2: sda_lo <= 1'b1;
            default: begin scl_lo <= 1'b1; busy <= 1'b0; done <= 1'b1; end
          endcase
          OP_BIT: case (ph)
            2'd0: begin scl_lo <= 1'b1; sda_lo <= !txb; end
            2'd1: scl_lo <= 1'b0;
            2'd2: begin
              rxb <= sda_in;
              if (chk && txb && !sda_in) begin
                busy <= 1'b0; lost <= 1'b1; scl_lo <= 1'b0; sda_lo <= 1'b0;
              end
            end
            default: begin scl_lo <= 1'b1; busy <= 1'b0; done <= 1'b1; end
          endcase
          default: case (ph)
            2'd0: begin scl_lo <= 1'b1; sda_lo <= 1'b1; end
            2'd1: scl_lo <= 1'b0;
            2'd2: sda_lo <= 1'b0;
            default: begin busy <= 1'b0; done <= 1'b1; end
          endcase
        endcase
      end
    end
  end

  AST_DONE_LOST_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, lost})) else $error("done and lost together"); // R9
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (busy && op == OP_BIT && !scl_lo && $past(!scl_lo) && $past(busy)) |-> $stable(sda_lo))
    else $error("SDA moved while SCL high in a data bit"); // R4
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              ctl_en,
  input  logic              ctl_sta,
  input  logic              ctl_stp,
  input  logic              ctl_flg,
  input  logic              ack_en,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              phy_busy,
  input  logic              phy_done,
  input  logic              phy_lost,
  input  logic              phy_rxb,
  output logic              cmd_valid,
  output phy_op_t           cmd_op,
  output logic              cmd_txb,
  output logic              cmd_chk,
  output logic              flag,
  output logic [7:0]        stat,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] ACK_IDX = CW'(BYTE_W);

  seq_st_t           st;
  logic              pend, rep, first, rd_mode;
  logic [CW-1:0]     bi;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx_shl;
  logic              go, data_bit, rx_cyc, busy_st;

  assign go       = ctl_wr && ctl_en;
  assign data_bit = (bi != ACK_IDX);
  assign rx_cyc   = !first && rd_mode;
  assign tx_shl   = tx_byte << bi;
  assign busy_st  = (st == SQ_START) || (st == SQ_BYTE) || (st == SQ_STOP);
  assign rx_byte  = sh;
  assign rx_load  = (st == SQ_BYTE) && phy_done && !data_bit && rx_cyc;

  always_comb begin
    cmd_valid = busy_st && !pend && !phy_busy;
    cmd_op    = OP_BIT;
    cmd_txb   = 1'b1;
    cmd_chk   = 1'b0;
    if (st == SQ_START) cmd_op = OP_START;
    else if (st == SQ_STOP) cmd_op = OP_STOP;
    else if (data_bit) begin
      cmd_txb = rx_cyc ? 1'b1 : tx_shl[BYTE_W-1];
      cmd_chk = !rx_cyc;
    end else begin
      cmd_txb = rx_cyc ? !ack_en : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE; pend <= 1'b0; rep <= 1'b0; first <= 1'b0; rd_mode <= 1'b0;
      bi <= '0; sh <= '0; flag <= 1'b0; stat <= ST_IDLE;
    end else begin
      if (cmd_valid) pend <= 1'b1;
      case (st)
        SQ_IDLE: begin
          if (go && !ctl_flg) flag <= 1'b0;
          if (go && ctl_sta) begin flag <= 1'b0; rep <= 1'b0; st <= SQ_START; end
        end
        SQ_HOLD: begin
          if (go && ctl_sta) begin flag <= 1'b0; rep <= 1'b1; st <= SQ_START; end
          else if (go && ctl_stp) begin flag <= 1'b0; st <= SQ_STOP; end
          else if (go && !ctl_flg) begin flag <= 1'b0; bi <= '0; st <= SQ_BYTE; end
        end
        SQ_START: if (phy_done) begin
          pend <= 1'b0; stat <= rep ? ST_RSTART : ST_START;
          flag <= 1'b1; first <= 1'b1; st <= SQ_HOLD;
        end
        SQ_STOP: if (phy_done) begin
          pend <= 1'b0; stat <= ST_IDLE; st <= SQ_IDLE;
        end
        default: begin
          if (phy_lost) begin
            pend <= 1'b0; stat <= ST_ARB; flag <= 1'b1; st <= SQ_IDLE;
          end else if (phy_done) begin
            pend <= 1'b0;
            bi   <= bi + 1'b1;
            if (data_bit) sh <= {sh[BYTE_W-2:0], phy_rxb};
            else begin
              flag  <= 1'b1;
              first <= 1'b0;
              st    <= SQ_HOLD;
              if (first) begin
                rd_mode <= tx_byte[0];
                if (tx_byte[0]) stat <= phy_rxb ? ST_RA_NAK : ST_RA_ACK;
                else            stat <= phy_rxb ? ST_WA_NAK : ST_WA_ACK;
              end else if (rd_mode) stat <= ack_en ? ST_RD_ACK : ST_RD_NAK;
              else                  stat <= phy_rxb ? ST_TD_NAK : ST_TD_ACK;
            end
          end
        end
      endcase
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !ctl_wr) |=> flag) else $error("flag dropped without a write"); // R3
  AST_QUIET_WHILE_FLAG: assert property (@(posedge clk) disable iff (rst)
    flag |-> !cmd_valid) else $error("bus step issued while flag set"); // R3
  AST_STATUS_ON_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> stat != ST_IDLE) else $error("flag rose with idle status"); // R2
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_tick,
  input  logic              ctl_wr,
  input  logic [5:0]        ctl_wdata,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] dat_wdata,
  input  logic              sda_in,
  output logic [BYTE_W-1:0] dat_rdata,
  output logic [7:0]        stat,
  output logic              flag,
  output logic              irq,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic              ien_q, aak_q;
  logic [BYTE_W-1:0] dat_q;
  logic              cmd_valid, cmd_txb, cmd_chk;
  phy_op_t           cmd_op;
  logic              p_busy, p_done, p_lost, p_rxb;
  logic              rx_load;
  logic [BYTE_W-1:0] rx_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0; aak_q <= 1'b0; dat_q <= '0;
    end else begin
      if (ctl_wr) begin
        ien_q <= ctl_wdata[CB_IEN];
        aak_q <= ctl_wdata[CB_AAK];
      end
      if (dat_wr) dat_q <= dat_wdata;
      else if (rx_load) dat_q <= rx_byte;
    end
  end

  assign dat_rdata = dat_q;
  assign irq       = flag && ien_q;

  i2cm_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr),
    .ctl_en(ctl_wdata[CB_EN]), .ctl_sta(ctl_wdata[CB_STA]),
    .ctl_stp(ctl_wdata[CB_STP]), .ctl_flg(ctl_wdata[CB_FLG]),
    .ack_en(aak_q), .tx_byte(dat_q),
    .phy_busy(p_busy), .phy_done(p_done), .phy_lost(p_lost), .phy_rxb(p_rxb),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_txb(cmd_txb), .cmd_chk(cmd_chk),
    .flag(flag), .stat(stat), .rx_load(rx_load), .rx_byte(rx_byte)
  );

  i2cm_bitphy u_phy (
    .clk(clk), .rst(rst), .tick(scl_tick),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_txb(cmd_txb), .cmd_chk(cmd_chk),
    .sda_in(sda_in), .busy(p_busy), .done(p_done), .lost(p_lost), .rxb(p_rxb),
    .scl_lo(scl_oe), .sda_lo(sda_oe)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (stat == ST_IDLE && !flag && !scl_oe && !sda_oe))
    else $error("state after reset not idle"); // R1
  AST_LOST_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
    (flag && stat == ST_ARB) |-> (!scl_oe && !sda_oe))
    else $error("bus held after arbitration loss"); // R9
endmodule

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/1ps
module sim_i2c_byte_master;
  localparam logic [5:0] EN = 6'h20, STA = 6'h10, STP = 6'h08, FLG = 6'h04, AAK = 6'h02, IEN = 6'h01;
  localparam logic [6:0] SLV = 7'h5A;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, ctl_wr = 1'b0, dat_wr = 1'b0, foreign = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic [7:0] dat_wdata = '0;
  logic [7:0] dat_rdata, stat;
  logic flag, irq, scl_oe, sda_oe;
  logic slv_lo = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slv_lo || foreign);

  int total = 0, bad = 0, starts = 0, stops = 0, n_load = 0, n_exp = 0;
  logic [7:0] rx_last = '0;

  i2c_byte_master u0 (
    .clk(clk), .rst(rst), .scl_tick(tick), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .sda_in(sda_line), .dat_rdata(dat_rdata),
    .stat(stat), .flag(flag), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] slv_byte(input int n);
    return 8'h3C ^ 8'(n * 29);
  endfunction

  initial begin
    logic [1:0] tc = 2'd0;
    forever begin
      @(negedge clk);
      tc = tc + 2'd1;
      tick = (tc == 2'd3);
    end
  end

  // target model on the bus lines
  initial begin
    logic psc = 1'b1, psda = 1'b1, s, d;
    logic active = 1'b0, txing = 1'b0, is_addr = 1'b0, ack = 1'b0, mack = 1'b0;
    logic [3:0] bc = '0;
    logic [7:0] sh = '0, tb = '0;
    forever begin
      @(negedge clk);
      s = scl_line; d = sda_line;
      if (psc && s && psda && !d) begin
        starts++; active = 1; txing = 0; is_addr = 1; bc = 0; slv_lo = 0;
      end else if (psc && s && !psda && d) begin
        stops++; active = 0; slv_lo = 0;
      end else if (active && !psc && s) begin
        bc = bc + 4'd1;
        if (!txing && bc <= 8) sh = {sh[6:0], d};
        if (txing && bc == 9) mack = !d;
      end else if (active && psc && !s) begin
        if (!txing && bc == 8) begin
          if (is_addr) ack = (sh[7:1] == SLV);
          else begin ack = (sh != 8'hFF); rx_last = sh; end
          slv_lo = ack;
        end else if (txing && bc >= 1 && bc <= 7) slv_lo = !tb[7 - bc];
        else if (txing && bc == 8) slv_lo = 0;
        else if (bc == 9) begin
          bc = 0;
          if (!txing) begin
            if (!ack) begin active = 0; slv_lo = 0; end
            else if (is_addr && sh[0]) begin
              txing = 1; tb = slv_byte(n_load); n_load++; slv_lo = !tb[7];
            end else slv_lo = 0;
            is_addr = 0;
          end else if (mack) begin
            tb = slv_byte(n_load); n_load++; slv_lo = !tb[7];
          end else begin active = 0; slv_lo = 0; end
        end
      end
      psc = s; psda = d;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic [5:0] v);
    @(negedge clk); ctl_wdata = v; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic dat(input logic [7:0] v);
    @(negedge clk); dat_wdata = v; dat_wr = 1'b1;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (flag) break;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (stat == 8'hF8) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic do_stop(input string tag);
    int s0 = stops;
    ctl(EN | STP); wait_idle();
    check(stat == 8'hF8 && !flag, tag, stat, 8'hF8);
    check(!scl_oe && !sda_oe && stops == s0 + 1, tag, stops, s0 + 1);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic sc, sd;
    void'($urandom(32'h00C0FFEE));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(stat == 8'hF8, "R1 stat", stat, 8'hF8);
    check(!flag && !irq && !scl_oe && !sda_oe, "R1 flag/irq/lines", {flag, irq, scl_oe, sda_oe}, 0);

    // R11 start without enable
    ctl(STA | IEN);
    repeat (60) @(negedge clk);
    check(!flag && stat == 8'hF8 && starts == 0, "R11 no start", starts, 0);

    // R2 START from idle
    ctl(EN | STA | IEN); wait_flag();
    check(stat == 8'h08, "R2 stat", stat, 8'h08);
    check(starts == 1, "R2 start condition", starts, 1);
    check(irq, "R10 irq high", irq, 1);

    // R3 parked while flag set
    sc = scl_oe; sd = sda_oe;
    repeat (60) @(negedge clk);
    check(flag && stat == 8'h08 && scl_oe == sc && sda_oe == sd, "R3 hold", {flag, scl_oe, sda_oe}, {1'b1, sc, sd});

    // R11 / R10: no-enable write keeps flag, clears interrupt enable
    ctl(FLG);
    repeat (30) @(negedge clk);
    check(flag && stat == 8'h08, "R11 flag kept", flag, 1);
    check(!irq, "R10 irq masked", irq, 0);

    // R4 write address, R5 data ack / nak
    dat({SLV, 1'b0}); ctl(EN); wait_flag();
    check(stat == 8'h18, "R4 write addr ack", stat, 8'h18);
    dat(8'hC3); ctl(EN); wait_flag();
    check(stat == 8'h28, "R5 data ack", stat, 8'h28);
    check(rx_last == 8'hC3, "R5 byte on bus", rx_last, 8'hC3);
    dat(8'hFF); ctl(EN); wait_flag();
    check(stat == 8'h30, "R5 data nak", stat, 8'h30);

    // R7 repeated start, R4 read address, R6 read bytes
    ctl(EN | STA); wait_flag();
    check(stat == 8'h10 && starts == 2, "R7 repeated start", stat, 8'h10);
    dat({SLV, 1'b1}); ctl(EN | AAK); wait_flag();
    check(stat == 8'h40, "R4 read addr ack", stat, 8'h40);
    ctl(EN | AAK); wait_flag();
    check(stat == 8'h50, "R6 read ack stat", stat, 8'h50);
    check(dat_rdata == slv_byte(n_exp), "R6 read data", dat_rdata, slv_byte(n_exp));
    n_exp++;
    ctl(EN); wait_flag();
    check(stat == 8'h58, "R6 read nak stat", stat, 8'h58);
    check(dat_rdata == slv_byte(n_exp), "R6 last data", dat_rdata, slv_byte(n_exp));
    n_exp++;
    do_stop("R8 stop");

    // R4 address nak, both directions
    ctl(EN | STA); wait_flag();
    dat({7'h5B, 1'b0}); ctl(EN); wait_flag();
    check(stat == 8'h20, "R4 write addr nak", stat, 8'h20);
    do_stop("R8 stop after nak");
    ctl(EN | STA); wait_flag();
    dat({7'h5B, 1'b1}); ctl(EN); wait_flag();
    check(stat == 8'h48, "R4 read addr nak", stat, 8'h48);
    do_stop("R8 stop after read nak");

    // R9 arbitration loss
    ctl(EN | STA); wait_flag();
    foreign = 1'b1;
    dat({SLV, 1'b0}); ctl(EN); wait_flag();
    check(stat == 8'h38 && flag, "R9 lost stat", stat, 8'h38);
    @(negedge clk);
    check(!scl_oe && !sda_oe, "R9 lines released", {scl_oe, sda_oe}, 0);
    foreign = 1'b0;
    repeat (10) @(negedge clk);
    ctl(EN | STA); wait_flag();
    check(stat == 8'h08, "R9 fresh start", stat, 8'h08);
    do_stop("R8 stop after loss");

    // random transfers
    for (int t = 0; t < 24; t++) begin
      logic rd, good;
      int len;
      logic [7:0] exp_a;
      rd = 1'($urandom % 2);
      good = (($urandom % 5) != 0);
      len = 1 + int'($urandom % 3);
      ctl(EN | STA | 6'($urandom % 2)); wait_flag();
      check(stat == 8'h08, "R2 random start", stat, 8'h08);
      check(irq == u0_ien(), "R10 random irq", irq, u0_ien());
      dat({good ? SLV : 7'h5B, rd}); ctl(EN | AAK); wait_flag();
      exp_a = rd ? (good ? 8'h40 : 8'h48) : (good ? 8'h18 : 8'h20);
      check(stat == exp_a, "R4 random addr", stat, exp_a);
      if (good) begin
        for (int i = 0; i < len; i++) begin
          if (rd) begin
            logic last;
            last = (i == len - 1);
            ctl(EN | (last ? 6'h00 : AAK)); wait_flag();
            check(stat == (last ? 8'h58 : 8'h50), "R6 random stat", stat, last ? 8'h58 : 8'h50);
            check(dat_rdata == slv_byte(n_exp), "R6 random data", dat_rdata, slv_byte(n_exp));
            n_exp++;
          end else begin
            logic [7:0] d;
            d = 8'($urandom);
            if ($urandom % 6 == 0) d = 8'hFF;
            dat(d); ctl(EN); wait_flag();
            check(stat == ((d == 8'hFF) ? 8'h30 : 8'h28), "R5 random stat", stat, (d == 8'hFF) ? 8'h30 : 8'h28);
            check(rx_last == d, "R5 random byte", rx_last, d);
            if (d == 8'hFF) break;
          end
        end
      end
      do_stop("R8 random stop");
    end

    summary();
    $finish;
  end

  // interrupt enable expected from the last control word the bench wrote
  function automatic logic u0_ien();
    return ctl_wdata[0];
  endfunction
endmodule